// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block sits on the host side of a configurable logic device and loads a configuration bitstream into it over a one-bit serial port. It drives three pins toward the device: a program strobe, a serial data line and a configuration clock. It watches two pins from the device, an init indication and a done indication. Bitstream bytes arrive on a valid/ready byte stream. A one-cycle start pulse and a byte count begin a load.

A load runs through a fixed sequence. The block raises program and waits for the device to show init. It then drops program and waits for init to clear. It shifts the bytes out most significant bit first, one bit per configuration-clock period. Before each byte it looks for the CRC-error signature: init active while done is low. After the last byte it holds the data line high and keeps pulsing the clock until the device raises done. Every wait has a bounded time. The outcome is a one-cycle finish pulse and an error code. A readback request is refused at once, because this port has no readback.

Top module: `ss_cfg_loader`

## Requirements
- R1: On start, program goes high and stays high until init is seen. If init is not seen within TIMEOUT cycles, the load ends with error code 1. The finish pulse then appears TIMEOUT+1 cycles after the cycle in which start was presented.
- R2: Program drops in the cycle after init is seen. The block then waits for init to go low. If init is still high after TIMEOUT cycles of this wait, the load ends with error code 2.
- R3: Each byte goes out as 8 bits, bit 7 first and bit 0 last. The data line is valid at each rising edge of the configuration clock. While busy, the data line changes only when the configuration clock is low.
- R4: Within a byte, every bit holds the configuration clock low for HALF_CYC cycles and then high for HALF_CYC cycles. A byte's last high phase lasts until the next byte begins.
- R5: Before each byte is taken, if init is high while done is low, the load stops at once with error code 3. No further byte is accepted.
- R6: The ready output is high only while the block is busy, program is low and a byte is awaited. Exactly byte_count bytes are consumed. Idle cycles on the valid input only delay the load.
- R7: After the last byte the data line stays high and the clock keeps pulsing with the same divider. Once done is seen high, the block finishes with error code 0 and issues no further rising edge.
- R8: If done does not rise within TIMEOUT cycles of the final clocking phase, the load ends with error code 4.
- R9: A readback request while idle produces a finish pulse in the next cycle with error code 5. No pin moves. The request wins over a start presented in the same cycle, and that start is dropped.
- R10: A byte count of zero skips shifting. After the init handshake the block goes straight to the final clocking phase.
- R11: After reset and whenever idle, program, configuration clock, data, busy, ready and finish are all low, and the error code is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a load when idle |
| readback_i | input | 1 | Readback request; always refused |
| byte_count_i | input | CNT_W | Number of bitstream bytes, sampled with start |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte on s_data_i is valid |
| s_ready_o | output | 1 | Block takes the byte this cycle if valid |
| prog_o | output | 1 | Program strobe to the device, high = asserted |
| cclk_o | output | 1 | Configuration clock to the device |
| cdata_o | output | 1 | Serial configuration data to the device |
| init_i | input | 1 | Device init indication, high = active |
| done_i | input | 1 | Device done indication, high = configured |
| busy_o | output | 1 | A load is in progress |
| fin_o | output | 1 | One-cycle pulse when a load or request ends |
| err_o | output | 3 | Outcome: 0 ok, 1 init-start timeout, 2 init-clear timeout, 3 CRC error, 4 done timeout, 5 readback refused |

## Verification
The assertions check on every cycle that ready is gated to the loading phase and that the pins are quiet when idle. They also check that data never changes while the configuration clock is high and that the final clocking phase keeps data high. Further cycle checks cover the CRC signature stopping the load on the next edge, the immediate refusal of readback, and the rule that a clean finish follows a sampled done. Only the bench scenarios can show that the right bits leave in the right order, that the low and high phases have the divider's length, and that the count of consumed bytes and rising edges is exact. The same holds for the exact latency of each timeout and for the behaviour of a zero-length load.

// File: rtl/ss_cfg_pkg.sv
package ss_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_WCLR  = 3'd2,
        ST_CHECK = 3'd3,
        ST_SHIFT = 3'd4,
        ST_FLUSH = 3'd5
    } ld_state_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_INIT_START = 3'd1,
        ERR_INIT_CLEAR = 3'd2,
        ERR_CRC        = 3'd3,
        ERR_DONE_TO    = 3'd4,
        ERR_READBACK   = 3'd5
    } ld_err_e;

    typedef struct packed {
        logic prog;
        logic cclk;
        logic cdata;
    } pin_s;

    function automatic logic is_timed(ld_state_e s);
        return (s == ST_PROG) || (s == ST_WCLR) || (s == ST_FLUSH);
    endfunction

endpackage

// File: rtl/ss_timeout.sv
module ss_timeout #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    localparam int TO_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != TO_W'(TIMEOUT - 1))
            cnt <= cnt + TO_W'(1);
    end

    assign expired = (cnt == TO_W'(TIMEOUT - 1));
endmodule

// File: rtl/ss_bitclk.sv
module ss_bitclk #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic rise,
    output logic wrap
);
    localparam int PERIOD = 2 * HALF_CYC;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || clr)
            ph <= '0;
        else if (ph == PH_W'(PERIOD - 1))
            ph <= '0;
        else
            ph <= ph + PH_W'(1);
    end

    assign rise = (ph == PH_W'(HALF_CYC - 1));
    assign wrap = (ph == PH_W'(PERIOD - 1));
endmodule

// File: rtl/ss_serializer.sv
module ss_serializer
    import ss_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [BYTE_W-2:0] din_low,
    output logic              next_bit
);
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (load)
            sh <= {din_low, 1'b0};
        else if (adv)
            sh <= {sh[BYTE_W-2:0], 1'b0};
    end

    assign next_bit = sh[BYTE_W-1];
endmodule

// File: rtl/ss_cfg_loader.sv
module ss_cfg_loader
    import ss_cfg_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int TIMEOUT  = 1000000,
    parameter int CNT_W    = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             readback_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             prog_o,
    output logic             cclk_o,
    output logic             cdata_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [2:0]       err_o
);
    localparam int BIT_W = $clog2(BYTE_W);

    ld_state_e        st, nxt;
    pin_s             pins, np;
    logic [CNT_W-1:0] rem, nrem;
    logic [BIT_W-1:0] bit_idx, nbit;
    logic             fin_q, nfin;
    ld_err_e          err_q, nerr;

    logic    ser_load, ser_adv, ser_next;
    logic    tmr_clr, tmr_exp;
    logic    ph_clr, ph_rise, ph_wrap;
    logic    fail;
    ld_err_e fcode;
    logic    crc_seen;

    assign crc_seen = init_i && !done_i;

    ss_timeout #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .expired(tmr_exp)
    );

    ss_bitclk #(.HALF_CYC(HALF_CYC)) u_div (
        .clk(clk), .rst(rst), .clr(ph_clr), .rise(ph_rise), .wrap(ph_wrap)
    );

    ss_serializer u_ser (
        .clk(clk), .rst(rst), .load(ser_load), .adv(ser_adv),
        .din_low(s_data_i[BYTE_W-2:0]), .next_bit(ser_next)
    );

    always_comb begin
        nxt      = st;
        np       = pins;
        nrem     = rem;
        nbit     = bit_idx;
        nfin     = 1'b0;
        nerr     = err_q;
        ser_load = 1'b0;
        ser_adv  = 1'b0;
        fail     = 1'b0;
        fcode    = ERR_NONE;
        unique case (st)
            ST_IDLE: begin
                if (readback_i) begin
                    nfin = 1'b1;
                    nerr = ERR_READBACK;
                end else if (start_i) begin
                    nxt     = ST_PROG;
                    np.prog = 1'b1;
                    nrem    = byte_count_i;
                    nerr    = ERR_NONE;
                end
            end
            ST_PROG: begin
                if (init_i) begin
                    nxt     = ST_WCLR;
                    np.prog = 1'b0;
                end else if (tmr_exp) begin
                    fail  = 1'b1;
                    fcode = ERR_INIT_START;
                end
            end
            ST_WCLR: begin
                if (!init_i)
                    nxt = ST_CHECK;
                else if (tmr_exp) begin
                    fail  = 1'b1;
                    fcode = ERR_INIT_CLEAR;
                end
            end
            ST_CHECK: begin
                if (rem == '0) begin
                    nxt      = ST_FLUSH;
                    np.cclk  = 1'b0;
                    np.cdata = 1'b1;
                end else if (crc_seen) begin
                    fail  = 1'b1;
                    fcode = ERR_CRC;
                end else if (s_valid_i) begin
                    nxt      = ST_SHIFT;
                    ser_load = 1'b1;
                    np.cclk  = 1'b0;
                    np.cdata = s_data_i[BYTE_W-1];
                    nrem     = rem - CNT_W'(1);
                    nbit     = '0;
                end
            end
            ST_SHIFT: begin
                if (ph_rise)
                    np.cclk = 1'b1;
                else if (ph_wrap) begin
                    if (bit_idx == BIT_W'(BYTE_W - 1))
                        nxt = ST_CHECK;
                    else begin
                        nbit     = bit_idx + BIT_W'(1);
                        ser_adv  = 1'b1;
                        np.cclk  = 1'b0;
                        np.cdata = ser_next;
                    end
                end
            end
            ST_FLUSH: begin
                if (done_i) begin
                    nxt  = ST_IDLE;
                    nfin = 1'b1;
                    nerr = ERR_NONE;
                    np   = '0;
                end else if (tmr_exp) begin
                    fail  = 1'b1;
                    fcode = ERR_DONE_TO;
                end else if (ph_rise)
                    np.cclk = 1'b1;
                else if (ph_wrap)
                    np.cclk = 1'b0;
            end
            default: nxt = ST_IDLE;
        endcase
        if (fail) begin
            nxt  = ST_IDLE;
            nfin = 1'b1;
            nerr = fcode;
            np   = '0;
        end
    end

    assign tmr_clr = (nxt != st) || !is_timed(st);
    assign ph_clr  = !((st == ST_SHIFT) || (st == ST_FLUSH));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pins    <= '0;
            rem     <= '0;
            bit_idx <= '0;
            fin_q   <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            st      <= nxt;
            pins    <= np;
            rem     <= nrem;
            bit_idx <= nbit;
            fin_q   <= nfin;
            err_q   <= nerr;
        end
    end

    assign s_ready_o = (st == ST_CHECK) && (rem != '0) && !crc_seen;
    assign prog_o    = pins.prog;
    assign cclk_o    = pins.cclk;
    assign cdata_o   = pins.cdata;
    assign busy_o    = (st != ST_IDLE);
    assign fin_o     = fin_q;
    assign err_o     = err_q;
endmodule

// File: rtl/ss_cfg_loader_chk.sv
module ss_cfg_loader_chk
    import ss_cfg_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             readback_i,
    input logic             s_ready_o,
    input logic             prog_o,
    input logic             cclk_o,
    input logic             cdata_o,
    input logic             init_i,
    input logic             done_i,
    input logic             busy_o,
    input logic             fin_o,
    input logic [2:0]       err_o,
    input ld_state_e        st,
    input logic [CNT_W-1:0] rem
);
    p_ready_gate_r6: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> (busy_o && !prog_o));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!prog_o && !cclk_o && !cdata_o && !s_ready_o));

    p_data_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !$stable(cdata_o)) |-> !cclk_o);

    p_crc_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHECK && rem != '0 && init_i && !done_i) |=> (fin_o && err_o == ERR_CRC));

    p_readback_refused_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && readback_i) |=> (fin_o && err_o == ERR_READBACK && !prog_o && !busy_o));

    p_flush_data_high_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLUSH) |-> cdata_o);

    p_ok_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        (fin_o && err_o == ERR_NONE) |-> $past(done_i));

    p_fin_single_r7: assert property (@(posedge clk) disable iff (rst)
        fin_o |=> !fin_o);
endmodule

bind ss_cfg_loader ss_cfg_loader_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .readback_i(readback_i), .s_ready_o(s_ready_o),
    .prog_o(prog_o), .cclk_o(cclk_o), .cdata_o(cdata_o), .init_i(init_i),
    .done_i(done_i), .busy_o(busy_o), .fin_o(fin_o), .err_o(err_o),
    .st(st), .rem(rem)
);

// File: tb/sim_ss_cfg_loader.sv
module sim_ss_cfg_loader;
    localparam int HALF = 2;
    localparam int TO   = 40;
    localparam int CW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          readback_i = 1'b0;
    logic [CW-1:0] byte_count_i = '0;
    logic [7:0]    s_data_i = '0;
    logic          s_valid_i = 1'b0;
    logic          s_ready_o, prog_o, cclk_o, cdata_o, busy_o, fin_o;
    logic          init_i = 1'b0;
    logic          done_i = 1'b0;
    logic [2:0]    err_o;

    ss_cfg_loader #(.HALF_CYC(HALF), .TIMEOUT(TO), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .readback_i(readback_i),
        .byte_count_i(byte_count_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
        .s_ready_o(s_ready_o), .prog_o(prog_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
        .init_i(init_i), .done_i(done_i), .busy_o(busy_o), .fin_o(fin_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    task automatic check(input bit cond, input string req, input int act, input int exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stimulus and device model state
    logic [7:0] bytes [8];
    int  nbytes = 0;
    int  idx = 0;
    bit  xfer_pend = 0;
    bit  expq [$];
    int  rises = 0, flush_rises = 0;
    int  lo_run = 0, hi_run = 0;
    bit  lo_ok = 0, hi_ok = 0;
    bit  prev_clk = 0;
    int  cyc = 0;
    bit  gap = 0, no_init = 0, stuck = 0, cleared = 0;
    int  crc_at = -1, done_after = -1;
    int  hi_cnt = 0, lo_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // reference comparison of the serial stream
            if (cclk_o && !prev_clk) begin
                rises++;
                if (expq.size() > 0) begin
                    bit e;
                    e = expq.pop_front();
                    check(cdata_o == e, "R3 bit value", cdata_o, e);
                end else begin
                    flush_rises++;
                    check(cdata_o == 1'b1, "R7 flush data", cdata_o, 1);
                end
                if (lo_ok) check(lo_run == HALF, "R4 low phase", lo_run, HALF);
                hi_run = 1;
                hi_ok  = 1;
            end else if (cclk_o) begin
                hi_run++;
            end
            if (!cclk_o && prev_clk) begin
                if (hi_ok && (rises % 8 != 0) && flush_rises == 0)
                    check(hi_run == HALF, "R4 high phase", hi_run, HALF);
                lo_run = 1;
                lo_ok  = 1;
            end else if (!cclk_o) begin
                lo_run++;
            end
            check(!s_ready_o || (busy_o && !prog_o), "R6 ready gating", s_ready_o, 0);

            // byte feeder
            if (xfer_pend) begin
                idx++;
                xfer_pend = 0;
            end
            s_valid_i = (idx < nbytes) && !(gap && (cyc % 2 == 1));
            s_data_i  = (idx < 8) ? bytes[idx] : 8'h00;
            if (s_valid_i && s_ready_o) begin
                xfer_pend = 1;
                for (int b = 7; b >= 0; b--) expq.push_back(s_data_i[b]);
            end

            // device model
            if (prog_o) begin
                hi_cnt++;
                lo_cnt = 0;
                if (hi_cnt >= 2 && !no_init) init_i = 1'b1;
            end else begin
                hi_cnt = 0;
                if (init_i && !cleared && !stuck) begin
                    lo_cnt++;
                    if (lo_cnt >= 3) begin
                        init_i  = 1'b0;
                        cleared = 1;
                    end
                end
            end
            if (crc_at >= 0 && cleared && rises == crc_at) init_i = 1'b1;
            if (done_after > 0 && flush_rises >= done_after) done_i = 1'b1;
            prev_clk = cclk_o;
            cyc++;
        end
    end

    task automatic prep(input int n, input bit g, input bit ni, input bit stk,
                        input int ca, input int da);
        @(negedge clk);
        nbytes = n; idx = 0; xfer_pend = 0; expq.delete();
        rises = 0; flush_rises = 0; lo_ok = 0; hi_ok = 0;
        gap = g; no_init = ni; stuck = stk; cleared = 0;
        crc_at = ca; done_after = da; hi_cnt = 0; lo_cnt = 0;
        init_i = 1'b0; done_i = 1'b0;
        byte_count_i = CW'(n);
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int exp_err, input int exp_rises,
                       input int exp_bytes, input int exp_lat);
        int lat;
        bit got;
        lat = 0;
        got = 0;
        start_i = 1'b1;
        while (!got && lat < 3000) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
            if (fin_o) got = 1;
        end
        check(got, {tag, " finish seen"}, got, 1);
        check(err_o == 3'(exp_err), {tag, " error code"}, err_o, exp_err);
        if (exp_rises >= 0) check(rises == exp_rises, {tag, " rising edges"}, rises, exp_rises);
        if (exp_bytes >= 0) check(idx == exp_bytes, {tag, " bytes taken"}, idx, exp_bytes);
        if (exp_lat >= 0) check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        @(negedge clk);
        check(!busy_o && !prog_o && !cclk_o, {tag, " idle after"}, busy_o, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!prog_o && !cclk_o && !cdata_o, "R11 pins after reset", prog_o, 0);
        check(!busy_o && !s_ready_o && !fin_o, "R11 status after reset", busy_o, 0);
        check(err_o == 3'd0, "R11 error after reset", err_o, 0);

        // R3 R4 R6 R7: plain load of three bytes
        bytes[0] = 8'hA5; bytes[1] = 8'h3C; bytes[2] = 8'h81;
        prep(3, 0, 0, 0, -1, 2);
        run("R7 load ok", 0, 26, 3, -1);

        // R6 with a stalling source
        bytes[0] = 8'h01; bytes[1] = 8'hFE; bytes[2] = 8'h70; bytes[3] = 8'h0F;
        prep(4, 1, 0, 0, -1, 3);
        run("R6 stalled load", 0, 35, 4, -1);

        // R1 init never seen
        prep(2, 0, 1, 0, -1, 2);
        run("R1 init start timeout", 1, 0, 0, TO + 1);

        // R2 init never clears
        prep(2, 0, 0, 1, -1, 2);
        run("R2 init clear timeout", 2, 0, 0, TO + 3);

        // R5 CRC signature after first byte
        bytes[0] = 8'hC3; bytes[1] = 8'h55; bytes[2] = 8'hAA;
        prep(3, 0, 0, 0, 8, 2);
        run("R5 crc stop", 3, 8, 1, -1);

        // R8 done never rises
        bytes[0] = 8'h96;
        prep(1, 0, 0, 0, -1, -1);
        run("R8 done timeout", 4, -1, 1, -1);

        // R10 zero-length load
        prep(0, 0, 0, 0, -1, 3);
        run("R10 zero count", 0, 3, 0, -1);

        // R9 readback refused, with a simultaneous start
        @(negedge clk);
        readback_i = 1'b1;
        start_i    = 1'b1;
        @(negedge clk);
        readback_i = 1'b0;
        start_i    = 1'b0;
        check(fin_o == 1'b1, "R9 finish next cycle", fin_o, 1);
        check(err_o == 3'd5, "R9 readback code", err_o, 5);
        check(!prog_o && !busy_o, "R9 no pin moves", prog_o, 0);
        @(negedge clk);
        check(!busy_o && !prog_o && !fin_o, "R9 start dropped", busy_o, 0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #1500000;
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule